// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

The block collects interrupt events from on-chip sources and stores each one as a 16-byte vector in a circular ring that lives in system memory. Every accepted event becomes four 32-bit memory writes at consecutive byte addresses. A byte-granular write pointer then moves forward by 16 and wraps at the programmed ring size. The host consumes vectors and reports how far it has read by writing a read-pointer register. The block keeps a level interrupt asserted while unread vectors remain.

If the producer runs the write pointer all the way round onto the read pointer, the block raises a sticky overflow flag in bit 0 of the write-pointer word, and the host recovers from that flag. When writeback is enabled, the block sends the write-pointer word to a programmable memory address after every vector, so the host can poll memory instead of a register. Event input and memory output both use valid/grant handshakes. Events are held off, never dropped.

Register map (3-bit address):

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit0 ring enable, bit1 interrupt enable, bit2 writeback enable, bit3 overflow clear (write-only pulse) |
| 1 | size | log2 of the ring size in 32-bit words |
| 2 | base | ring address bits [39:8] |
| 3 | writeback low | address [31:0], bits [1:0] forced to zero |
| 4 | writeback high | address [39:32] |
| 5 | read pointer | byte offset |
| 6 | write pointer | byte offset, overflow flag in bit 0 |

Top module: `irq_vec_ring`

## Requirements
- R1: After synchronous reset every register reads zero and `irq`, `mem_req` and `ev_ready` are low.
- R2: An accepted event produces four word writes at byte addresses base*256 + wptr + 0, 4, 8 and 12, in that order. The words are:
  - word 0 = source id in [7:0], all other bits zero;
  - word 1 = event data in [27:0], bits [31:28] zero;
  - word 2 = {pasid[31:16], vm id[15:8], ring id[7:0]};
  - word 3 = zero.
- R3: After the fourth word, the write pointer becomes (wptr + 16) AND (2^(size+2) - 1). Size is clamped to the range 2 to LOG2_WORDS_MAX.
- R4: If the advanced write pointer equals the read pointer, the overflow flag is set. It reads as bit 0 of the write-pointer register and stays set until it is cleared.
- R5: Writing control with bit 3 set clears the overflow flag. If the flag is set and cleared on the same edge, the set wins. Bit 3 reads back as zero.
- R6: `ev_ready` is high only when the ring enable is set and no vector is in progress. With the ring disabled, no event is taken and `mem_req` stays low.
- R7: `irq` is a registered copy of (interrupt enable AND (rptr != wptr OR overflow)). It falls in the cycle after a read-pointer write makes the pointers equal, and it is low whenever interrupt enable is off.
- R8: With writeback enabled, a fifth write follows each vector. It goes to the writeback address with bits [1:0] zero, and its data is the updated write-pointer word including the overflow flag.
- R9: `mem_req`, `mem_addr` and `mem_wdata` hold steady until `mem_gnt`, and `ev_ready` stays low while a vector is being written.
- R10: A write to the read pointer takes effect at any time. A write to the write pointer is ignored while the ring is enabled and is accepted, 16-byte aligned and masked to the ring, while it is disabled.
- R11: Register read data appears on `reg_rdata` one cycle after `reg_addr` is presented, and is laid out as in the register map above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted when high with ev_valid |
| ev_src | input | 8 | Source id |
| ev_data | input | 28 | Event data |
| ev_ring | input | 8 | Ring id |
| ev_vm | input | 8 | VM id |
| ev_pasid | input | 16 | Process address space id |
| mem_req | output | 1 | Memory write request |
| mem_gnt | input | 1 | Memory write accepted |
| mem_addr | output | 40 | Byte address of the write |
| mem_wdata | output | 32 | Write data |
| irq | output | 1 | Pending-interrupt level |

## Verification
The case that needs the most care is an overflow being flagged on the same clock edge as a host command that clears the flag. The memory grant is withheld until only the fourth word of a vector is outstanding. The grant is then released in the same cycle as a control write with the clear bit set, so both effects land on one edge. The outcome is judged by reading the write-pointer register: the flag must still be set, with the pointer advanced by one vector.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int REG_W = 32;
  localparam int RA_W  = 3;

  localparam logic [RA_W-1:0] RA_CTRL = 3'd0;
  localparam logic [RA_W-1:0] RA_SIZE = 3'd1;
  localparam logic [RA_W-1:0] RA_BASE = 3'd2;
  localparam logic [RA_W-1:0] RA_WBLO = 3'd3;
  localparam logic [RA_W-1:0] RA_WBHI = 3'd4;
  localparam logic [RA_W-1:0] RA_RPTR = 3'd5;
  localparam logic [RA_W-1:0] RA_WPTR = 3'd6;

  localparam int CB_RING = 0;
  localparam int CB_IRQ  = 1;
  localparam int CB_WB   = 2;
  localparam int CB_CLR  = 3;

  localparam int VEC_WORDS = 4;
  localparam int VEC_BYTES = 16;

  typedef enum logic [1:0] {SQ_IDLE, SQ_DATA, SQ_WBLD, SQ_WB} sq_state_t;
endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int LOG2_WORDS_MAX = 14,
  parameter int ADDR_W         = 40,
  localparam int PTR_W = LOG2_WORDS_MAX + 2,
  localparam int SZ_W  = $clog2(LOG2_WORDS_MAX + 1),
  localparam int HI_W  = ADDR_W - REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              adv,
  output logic              ring_en,
  output logic              wb_en,
  output logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [PTR_W-1:0]  wptr,
  output logic [REG_W-1:0]  wptr_word,
  output logic              irq
);
  logic              ring_en_q, irq_en_q, wb_en_q, ovf_q, irq_q;
  logic [SZ_W-1:0]   size_q, size_eff;
  logic [REG_W-1:0]  base_q, wbl_q;
  logic [HI_W-1:0]   wbh_q;
  logic [PTR_W-1:0]  rptr_q, wptr_q, ring_mask, align_mask, wptr_nxt;
  logic              wr_ctrl, wr_rptr, wr_wptr, ovf_clr, ovf_set;

  always_comb begin
    if (size_q < SZ_W'(2))                   size_eff = SZ_W'(2);
    else if (size_q > SZ_W'(LOG2_WORDS_MAX)) size_eff = SZ_W'(LOG2_WORDS_MAX);
    else                                     size_eff = size_q;
  end

  assign ring_mask  = {PTR_W{1'b1}} >> (LOG2_WORDS_MAX - int'(size_eff));
  assign align_mask = ring_mask & ~PTR_W'(VEC_BYTES - 1);
  assign wptr_nxt   = (wptr_q + PTR_W'(VEC_BYTES)) & ring_mask;

  assign wr_ctrl = reg_wr_en && (reg_addr == RA_CTRL);
  assign wr_rptr = reg_wr_en && (reg_addr == RA_RPTR);
  assign wr_wptr = reg_wr_en && (reg_addr == RA_WPTR) && !ring_en_q;
  assign ovf_clr = wr_ctrl && reg_wdata[CB_CLR];
  assign ovf_set = adv && (wptr_nxt == rptr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_en_q <= 1'b0;
      irq_en_q  <= 1'b0;
      wb_en_q   <= 1'b0;
      size_q    <= '0;
      base_q    <= '0;
      wbl_q     <= '0;
      wbh_q     <= '0;
    end else if (reg_wr_en) begin
      case (reg_addr)
        RA_CTRL: begin
          ring_en_q <= reg_wdata[CB_RING];
          irq_en_q  <= reg_wdata[CB_IRQ];
          wb_en_q   <= reg_wdata[CB_WB];
        end
        RA_SIZE: size_q <= reg_wdata[SZ_W-1:0];
        RA_BASE: base_q <= reg_wdata;
        RA_WBLO: wbl_q  <= {reg_wdata[REG_W-1:2], 2'b00};
        RA_WBHI: wbh_q  <= reg_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q <= '0;
      wptr_q <= '0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_rptr) rptr_q <= reg_wdata[PTR_W-1:0] & align_mask;
      if (adv)          wptr_q <= wptr_nxt;
      else if (wr_wptr) wptr_q <= reg_wdata[PTR_W-1:0] & align_mask;
      if (ovf_set)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      irq_q <= irq_en_q && ((rptr_q != wptr_q) || ovf_q);
    end
  end

  assign wptr_word = REG_W'(wptr_q) | {{(REG_W-1){1'b0}}, ovf_q};

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        RA_CTRL: reg_rdata <= REG_W'({wb_en_q, irq_en_q, ring_en_q});
        RA_SIZE: reg_rdata <= REG_W'(size_q);
        RA_BASE: reg_rdata <= base_q;
        RA_WBLO: reg_rdata <= wbl_q;
        RA_WBHI: reg_rdata <= REG_W'(wbh_q);
        RA_RPTR: reg_rdata <= REG_W'(rptr_q);
        RA_WPTR: reg_rdata <= wptr_word;
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign ring_en   = ring_en_q;
  assign wb_en     = wb_en_q;
  assign base_addr = {base_q, 8'h00};
  assign wb_addr   = {wbh_q, wbl_q};
  assign wptr      = wptr_q;
  assign irq       = irq_q;

  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (rst)
    adv |=> wptr_q == (($past(wptr_q) + PTR_W'(VEC_BYTES)) & $past(ring_mask))); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_q && !ovf_clr |=> ovf_q); // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !irq_en_q |=> !irq_q); // R7
  AST_EQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rptr_q == wptr_q) && !ovf_q |=> !irq_q); // R7
  AST_WPTR_LOCK: assert property (@(posedge clk) disable iff (rst)
    ring_en_q && !adv |=> $stable(wptr_q)); // R10
endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
  import ivr_pkg::*;
#(
  parameter int LOG2_WORDS_MAX = 14,
  parameter int ADDR_W         = 40,
  parameter int SRC_W          = 8,
  parameter int DATA_W         = 28,
  parameter int RING_W         = 8,
  parameter int VM_W           = 8,
  parameter int PASID_W        = 16,
  localparam int PTR_W = LOG2_WORDS_MAX + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ring_en,
  input  logic               wb_en,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [ADDR_W-1:0]  wb_addr,
  input  logic [PTR_W-1:0]   wptr,
  input  logic [REG_W-1:0]   wptr_word,
  input  logic               ev_valid,
  output logic               ev_ready,
  input  logic [SRC_W-1:0]   ev_src,
  input  logic [DATA_W-1:0]  ev_data,
  input  logic [RING_W-1:0]  ev_ring,
  input  logic [VM_W-1:0]    ev_vm,
  input  logic [PASID_W-1:0] ev_pasid,
  output logic               mem_req,
  input  logic               mem_gnt,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [REG_W-1:0]   mem_wdata,
  output logic               adv
);
  localparam int CNT_W = $clog2(VEC_WORDS);

  sq_state_t         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [REG_W-1:0]  vec_q [VEC_WORDS];
  logic [REG_W-1:0]  vec_new [VEC_WORDS];

  always_comb begin
    vec_new[0] = REG_W'(ev_src);
    vec_new[1] = REG_W'(ev_data);
    vec_new[2] = REG_W'({ev_pasid, ev_vm, ev_ring});
    for (int k = 3; k < VEC_WORDS; k++) vec_new[k] = '0;
  end

  assign ev_ready = (state_q == SQ_IDLE) && ring_en;
  assign adv      = (state_q == SQ_DATA) && mem_gnt && (cnt_q == CNT_W'(VEC_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_IDLE;
      cnt_q     <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      for (int k = 0; k < VEC_WORDS; k++) vec_q[k] <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (ring_en && ev_valid) begin
          for (int k = 0; k < VEC_WORDS; k++) vec_q[k] <= vec_new[k];
          mem_req   <= 1'b1;
          mem_addr  <= base_addr + ADDR_W'(wptr);
          mem_wdata <= vec_new[0];
          cnt_q     <= '0;
          state_q   <= SQ_DATA;
        end
        SQ_DATA: if (mem_gnt) begin
          if (cnt_q == CNT_W'(VEC_WORDS - 1)) begin
            mem_req <= 1'b0;
            state_q <= wb_en ? SQ_WBLD : SQ_IDLE;
          end else begin
            cnt_q     <= cnt_q + 1'b1;
            mem_addr  <= mem_addr + ADDR_W'(4);
            mem_wdata <= vec_q[cnt_q + 1'b1];
          end
        end
        SQ_WBLD: begin
          mem_req   <= 1'b1;
          mem_addr  <= wb_addr;
          mem_wdata <= wptr_word;
          state_q   <= SQ_WB;
        end
        SQ_WB: if (mem_gnt) begin
          mem_req <= 1'b0;
          state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)); // R9
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00); // R2
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !ev_ready); // R9
endmodule

// File: rtl/irq_vec_ring.sv
module irq_vec_ring
  import ivr_pkg::*;
#(
  parameter int LOG2_WORDS_MAX = 14,
  parameter int ADDR_W         = 40,
  parameter int SRC_W          = 8,
  parameter int DATA_W         = 28,
  parameter int RING_W         = 8,
  parameter int VM_W           = 8,
  parameter int PASID_W        = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr_en,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               ev_valid,
  output logic               ev_ready,
  input  logic [SRC_W-1:0]   ev_src,
  input  logic [DATA_W-1:0]  ev_data,
  input  logic [RING_W-1:0]  ev_ring,
  input  logic [VM_W-1:0]    ev_vm,
  input  logic [PASID_W-1:0] ev_pasid,
  output logic               mem_req,
  input  logic               mem_gnt,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [31:0]        mem_wdata,
  output logic               irq
);
  localparam int PTR_W = LOG2_WORDS_MAX + 2;

  logic              ring_en, wb_en, adv;
  logic [ADDR_W-1:0] base_addr, wb_addr;
  logic [PTR_W-1:0]  wptr;
  logic [REG_W-1:0]  wptr_word;

  ivr_regs #(.LOG2_WORDS_MAX(LOG2_WORDS_MAX), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .adv(adv),
    .ring_en(ring_en), .wb_en(wb_en), .base_addr(base_addr), .wb_addr(wb_addr),
    .wptr(wptr), .wptr_word(wptr_word), .irq(irq)
  );

  ivr_seq #(
    .LOG2_WORDS_MAX(LOG2_WORDS_MAX), .ADDR_W(ADDR_W), .SRC_W(SRC_W),
    .DATA_W(DATA_W), .RING_W(RING_W), .VM_W(VM_W), .PASID_W(PASID_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .ring_en(ring_en), .wb_en(wb_en), .base_addr(base_addr), .wb_addr(wb_addr),
    .wptr(wptr), .wptr_word(wptr_word),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_src(ev_src), .ev_data(ev_data),
    .ev_ring(ev_ring), .ev_vm(ev_vm), .ev_pasid(ev_pasid),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .adv(adv)
  );
endmodule

// File: tb/sim_irq_vec_ring.sv
module sim_irq_vec_ring;
  localparam int CLK_PERIOD = 10;
  localparam logic [39:0] BASE_BYTE = 40'h0001234500;
  localparam logic [39:0] WB_BYTE   = 40'h1200000104;
  localparam int NVEC = 6;
  // {src[67:60], data[59:32], ring[31:24], vm[23:16], pasid[15:0]}
  localparam logic [67:0] EVT [NVEC] = '{
    68'hA5_ABCDEF1_03_07_BEEF,
    68'h00_0000000_00_00_0000,
    68'hFF_FFFFFFF_FF_FF_FFFF,
    68'h12_3456789_AB_CD_EF01,
    68'h7E_8000001_01_80_8001,
    68'h3C_0F0F0F0_55_AA_5A5A
  };

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ev_valid = 1'b0, ev_ready;
  logic [7:0] ev_src = '0, ev_ring = '0, ev_vm = '0;
  logic [27:0] ev_data = '0;
  logic [15:0] ev_pasid = '0;
  logic mem_req, mem_gnt = 1'b1;
  logic [39:0] mem_addr;
  logic [31:0] mem_wdata;
  logic irq;

  int n_tests = 0, n_fail = 0;
  int cap_n = 0;
  logic [39:0] cap_a [16];
  logic [31:0] cap_d [16];
  logic toggle_gnt = 1'b0;
  logic [31:0] rv;
  int wp = 0, rp = 0;
  logic ovf = 1'b0;

  irq_vec_ring u0 (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_src(ev_src), .ev_data(ev_data), .ev_ring(ev_ring),
    .ev_vm(ev_vm), .ev_pasid(ev_pasid), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (mem_req && mem_gnt && cap_n < 16) begin
      cap_a[cap_n] = mem_addr;
      cap_d[cap_n] = mem_wdata;
      cap_n++;
    end
  end

  always @(posedge clk) begin
    #1;
    if (toggle_gnt) mem_gnt = ~mem_gnt;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic send(input logic [67:0] e);
    bit took = 0;
    @(posedge clk); #1;
    {ev_src, ev_data, ev_ring, ev_vm, ev_pasid} = e;
    ev_valid = 1'b1;
    while (!took) begin
      @(negedge clk);
      took = ev_ready;
    end
    @(posedge clk); #1;
    ev_valid = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!ev_ready);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_word(input logic [67:0] e, input int k);
    case (k)
      0: return {24'h0, e[67:60]};
      1: return {4'h0, e[59:32]};
      2: return {e[15:0], e[23:16], e[31:24]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check_vec(input logic [67:0] e, input int at, input string tag);
    for (int k = 0; k < 4; k++) begin
      chk({tag, " addr"}, cap_a[k], BASE_BYTE + 40'(at) + 40'(4*k));
      chk({tag, " data"}, cap_d[k], exp_word(e, k));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq", irq, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 ev_ready", ev_ready, 0);
    rd(3'd6, rv); chk("R1 wptr", rv, 0);
    rd(3'd0, rv); chk("R1 ctrl", rv, 0);

    // ring of 16 words = 64 bytes = 4 vectors
    wr(3'd1, 32'd4);
    wr(3'd2, 32'h00012345);
    wr(3'd3, 32'h00000107);
    wr(3'd4, 32'h00000012);
    wr(3'd0, 32'h7);
    rd(3'd1, rv); chk("R11 size", rv, 4);
    rd(3'd3, rv); chk("R11 wb lo aligned", rv, 32'h104);
    rd(3'd2, rv); chk("R11 base", rv, 32'h00012345);

    // table walk with writeback: wrap and overflow land on entry 3
    for (int i = 0; i < NVEC; i++) begin
      cap_n = 0;
      send(EVT[i]);
      wait_done();
      chk("R2 word count", cap_n, 5);
      check_vec(EVT[i], wp, "R2");
      wp = (wp + 16) & 63;
      if (wp == rp) ovf = 1'b1;
      chk("R8 wb addr", cap_a[4], WB_BYTE);
      chk("R8 wb data", cap_d[4], 32'(wp) | 32'(ovf));
      rd(3'd6, rv); chk("R3 R4 wptr word", rv, 32'(wp) | 32'(ovf));
      chk("R7 irq pending", irq, 1);
    end

    wr(3'd0, 32'hF);
    rd(3'd6, rv); chk("R5 clear", rv, 32);
    rd(3'd0, rv); chk("R5 clear bit reads zero", rv, 7);

    wr(3'd6, 32'h0);
    rd(3'd6, rv); chk("R10 wptr write ignored while enabled", rv, 32);

    wr(3'd5, 32'd32);
    @(negedge clk); chk("R7 irq one cycle after rptr write", irq, 1);
    @(negedge clk); chk("R7 irq falls", irq, 0);

    cap_n = 0;
    send(EVT[0]); wait_done();
    chk("R7 irq new vector", irq, 1);
    wr(3'd0, 32'h5);
    repeat (2) @(negedge clk);
    chk("R7 irq gated off", irq, 0);

    wr(3'd0, 32'h0);
    cap_n = 0;
    @(posedge clk); #1; ev_valid = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R6 no ready when disabled", ev_ready, 0);
    end
    @(posedge clk); #1; ev_valid = 1'b0;
    chk("R6 no writes when disabled", cap_n, 0);

    wr(3'd6, 32'h25);
    rd(3'd6, rv); chk("R10 wptr write accepted aligned", rv, 32'h20);
    wr(3'd6, 32'h0);
    wr(3'd5, 32'h0);
    rd(3'd6, rv); chk("R10 wptr zero", rv, 0);
    rd(3'd5, rv); chk("R10 rptr zero", rv, 0);
    wp = 0; rp = 0;

    wr(3'd0, 32'h3);
    toggle_gnt = 1'b1;
    cap_n = 0;
    send(EVT[3]);
    @(negedge clk); chk("R9 ev_ready low while busy", ev_ready, 0);
    wait_done();
    toggle_gnt = 1'b0; mem_gnt = 1'b1;
    chk("R9 word count under stall", cap_n, 4);
    check_vec(EVT[3], 0, "R9 stalled");
    rd(3'd6, rv); chk("R3 wptr after stall", rv, 16);

    // overflow set and clear on the same edge: set wins
    wr(3'd0, 32'h0);
    wr(3'd6, 32'h0);
    wr(3'd5, 32'd16);
    wr(3'd0, 32'h3);
    mem_gnt = 1'b0;
    cap_n = 0;
    send(EVT[5]);
    mem_gnt = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    reg_wr_en = 1'b1; reg_addr = 3'd0; reg_wdata = 32'hB;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
    chk("R5 collision words", cap_n, 4);
    rd(3'd6, rv); chk("R5 set wins over clear", rv, 17);
    wr(3'd0, 32'hB);
    rd(3'd6, rv); chk("R5 later clear", rv, 16);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule